// File: doc/BRIEF.md
# Lockable-Way Cache Victim Selector

This block picks the way that receives the next linefill in a set-associative cache whose ways can be locked one at a time. It keeps one valid bit per line, meaning per set and way. It also holds a lock mask with one bit per way, written by software. For each fill request it returns a one-hot victim way, a flag that says whether that line held valid data and is being evicted, and a flag that says no way can be allocated at all.

A locked way is never allocated, in any set. Its lines stay valid and can keep hitting, because locking does not invalidate anything. The selector first fills any unlocked way that is still empty, starting from the lowest-numbered one. When every unlocked way of the set is full, it picks one of the unlocked ways with a free-running pseudo-random generator. The pick is spread evenly over those ways, so with k unlocked ways each is chosen about 1/k of the time.

This supports a preload flow. Software locks every way except the target way and runs the fills, which all land in the target way. It then locks the target way and unlocks the others. Tag and data storage, hit detection and the bus side are outside this block.

Top module: `lockway_victim_sel`

## Requirements
- R1: After reset, resp_valid_o, victim_o, evict_o and no_victim_o are all 0, every valid bit is clear and the lock mask is 0.
- R2: A fill request sampled at one clock edge gives resp_valid_o = 1 in the following cycle, with victim_o one-hot and bit i meaning way i. In any cycle with no response, resp_valid_o and victim_o are 0.
- R3: If one or more unlocked ways of the requested set are invalid, the lowest-numbered invalid unlocked way is chosen, evict_o is 0, and that line becomes valid.
- R4: A way whose lock mask bit is 1 (bit i locks way i) is never chosen, in any set.
- R5: If every unlocked way of the set is valid, one of them is chosen with evict_o = 1. Over many fills with k unlocked ways, each unlocked way is chosen roughly 1/k of the time.
- R6: With all mask bits set, the response has no_victim_o = 1, victim_o = 0 and evict_o = 0, and no valid bit changes.
- R7: With exactly one unlocked way, every fill to every set goes to that way.
- R8: Locking a way leaves its valid lines untouched. After the way is unlocked again, those lines still count as valid.
- R9: A mask write sampled at clock edge e applies to fill requests sampled at edge e+1 and later. A fill sampled at edge e still uses the old mask.
- R10: An invalidate-all pulse sampled at one edge clears every valid bit at that edge and leaves the lock mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mask_we_i | input | 1 | Write enable for the lock mask |
| mask_wdata_i | input | NUM_WAYS | New lock mask value, bit i locks way i |
| inval_all_i | input | 1 | Clears all valid bits |
| fill_req_i | input | 1 | Linefill allocation request |
| fill_set_i | input | $clog2(NUM_SETS) | Set index of the fill |
| resp_valid_o | output | 1 | Response for the fill of the previous cycle |
| victim_o | output | NUM_WAYS | One-hot chosen way |
| evict_o | output | 1 | Chosen line held valid data |
| no_victim_o | output | 1 | All ways locked, nothing allocated |

## Verification
Every fill result is registered, so victim_o, evict_o and no_victim_o are due in the cycle after the edge that samples fill_req_i. The bench drives each request on a falling edge and reads the response on the next falling edge, which is exactly one rising edge later. Mask writes and invalidate-all pulses act at the rising edge that samples them. The bench checks this by placing a fill in the same cycle as a mask write, where the old mask must apply, and a fill in the next cycle, where the new mask must apply. A valid-bit model in the bench, updated after each response, gives the expected lowest free way or the legal eviction set for every fill of the sweep.

// File: rtl/lockway_pkg.sv
package lockway_pkg;
  localparam int unsigned LFSR_W = 16;
  // x^16 + x^14 + x^13 + x^11, Galois form
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef enum logic [1:0] {
    PICK_FREE = 2'd0,
    PICK_EVICT = 2'd1,
    PICK_NONE = 2'd2
  } pick_kind_e;
endpackage

// File: rtl/lockway_mask_reg.sv
module lockway_mask_reg #(
  parameter int unsigned NUM_WAYS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [NUM_WAYS-1:0] wdata_i,
  output logic [NUM_WAYS-1:0] lock_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lock_o <= '0;
    else if (we_i) lock_o <= wdata_i;
  end
endmodule

// File: rtl/lockway_lfsr.sv
module lockway_lfsr
  import lockway_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [LFSR_W-1:0] rnd_o
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= LFSR_SEED;
    else         state_q <= {1'b0, state_q[LFSR_W-1:1]} ^ (state_q[0] ? LFSR_TAPS : '0);
  end

  assign rnd_o = state_q;
endmodule

// File: rtl/lockway_valid_array.sv
module lockway_valid_array #(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned SET_W = $clog2(NUM_SETS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_all_i,
  input  logic                wr_en_i,
  input  logic [SET_W-1:0]    set_i,
  input  logic [NUM_WAYS-1:0] wr_way_i,
  output logic [NUM_WAYS-1:0] row_o
);
  logic [NUM_WAYS-1:0] vld_q [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 vld_q[s] <= '0;
      else if (clr_all_i)                          vld_q[s] <= '0;
      else if (wr_en_i && set_i == SET_W'(s))      vld_q[s] <= vld_q[s] | wr_way_i;
    end
  end

  assign row_o = vld_q[set_i];
endmodule

// File: rtl/lockway_pick.sv
module lockway_pick
  import lockway_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4
) (
  input  logic [NUM_WAYS-1:0] lock_i,
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic [LFSR_W-1:0]   rnd_i,
  output logic [NUM_WAYS-1:0] way_o,
  output pick_kind_e          kind_o
);
  localparam int unsigned CNT_W = $clog2(NUM_WAYS + 1);

  logic [NUM_WAYS-1:0] avail, free;
  logic [CNT_W-1:0]    n_avail;
  logic [LFSR_W-1:0]   nth;
  logic [NUM_WAYS-1:0] free_pick, rnd_pick;

  assign avail = ~lock_i;
  assign free  = avail & ~valid_i;

  always_comb begin
    n_avail = '0;
    for (int i = 0; i < NUM_WAYS; i++) n_avail = n_avail + CNT_W'(avail[i]);
  end

  // rank among unlocked ways; modulus bias of a 16-bit source is negligible
  assign nth = (n_avail == '0) ? '0 : rnd_i % LFSR_W'(n_avail);

  always_comb begin
    free_pick = '0;
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (free[i]) free_pick = NUM_WAYS'(1) << i;
    end
  end

  always_comb begin
    logic [LFSR_W-1:0] seen;
    seen     = '0;
    rnd_pick = '0;
    for (int i = 0; i < NUM_WAYS; i++) begin
      if (avail[i]) begin
        if (seen == nth) rnd_pick[i] = 1'b1;
        seen = seen + 1'b1;
      end
    end
  end

  always_comb begin
    if (avail == '0) begin
      kind_o = PICK_NONE;
      way_o  = '0;
    end else if (free != '0) begin
      kind_o = PICK_FREE;
      way_o  = free_pick;
    end else begin
      kind_o = PICK_EVICT;
      way_o  = rnd_pick;
    end
  end
endmodule

// File: rtl/lockway_victim_sel.sv
module lockway_victim_sel
  import lockway_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned SET_W = $clog2(NUM_SETS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                mask_we_i,
  input  logic [NUM_WAYS-1:0] mask_wdata_i,
  input  logic                inval_all_i,
  input  logic                fill_req_i,
  input  logic [SET_W-1:0]    fill_set_i,
  output logic                resp_valid_o,
  output logic [NUM_WAYS-1:0] victim_o,
  output logic                evict_o,
  output logic                no_victim_o
);
  logic [NUM_WAYS-1:0] lock_mask;
  logic [NUM_WAYS-1:0] row_vld;
  logic [LFSR_W-1:0]   rnd;
  logic [NUM_WAYS-1:0] pick_way;
  pick_kind_e          pick_kind;
  logic                alloc;

  lockway_mask_reg #(.NUM_WAYS(NUM_WAYS)) u_mask (
    .clk_i, .rst_ni, .we_i(mask_we_i), .wdata_i(mask_wdata_i), .lock_o(lock_mask)
  );

  lockway_lfsr u_lfsr (.clk_i, .rst_ni, .rnd_o(rnd));

  lockway_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .lock_i(lock_mask), .valid_i(row_vld), .rnd_i(rnd),
    .way_o(pick_way), .kind_o(pick_kind)
  );

  assign alloc = fill_req_i && (pick_kind != PICK_NONE);

  lockway_valid_array #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_vld (
    .clk_i, .rst_ni, .clr_all_i(inval_all_i), .wr_en_i(alloc),
    .set_i(fill_set_i), .wr_way_i(pick_way), .row_o(row_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      victim_o     <= '0;
      evict_o      <= 1'b0;
      no_victim_o  <= 1'b0;
    end else begin
      resp_valid_o <= fill_req_i;
      victim_o     <= fill_req_i ? pick_way : '0;
      evict_o      <= fill_req_i && (pick_kind == PICK_EVICT);
      no_victim_o  <= fill_req_i && (pick_kind == PICK_NONE);
    end
  end
endmodule

// File: rtl/lockway_victim_sel_chk.sv
module lockway_victim_sel_chk #(
  parameter int unsigned NUM_WAYS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                fill_req_i,
  input logic                resp_valid_o,
  input logic [NUM_WAYS-1:0] victim_o,
  input logic                evict_o,
  input logic                no_victim_o,
  input logic [NUM_WAYS-1:0] lock_mask
);
  a_r2_resp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_i |=> resp_valid_o);

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> (victim_o == '0 && !evict_o && !no_victim_o));

  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !no_victim_o) |-> ($countones(victim_o) == 1));

  a_r4_never_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_req_i |=> ((victim_o & $past(lock_mask)) == '0));

  a_r6_all_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_i && (&lock_mask)) |=> (no_victim_o && victim_o == '0 && !evict_o));

  a_r6_none_only_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_i && !(&lock_mask)) |=> !no_victim_o);
endmodule

bind lockway_victim_sel lockway_victim_sel_chk #(.NUM_WAYS(NUM_WAYS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fill_req_i(fill_req_i),
  .resp_valid_o(resp_valid_o), .victim_o(victim_o), .evict_o(evict_o),
  .no_victim_o(no_victim_o), .lock_mask(lock_mask)
);

// File: tb/lockway_victim_sel_tb.sv
module lockway_victim_sel_tb;
  localparam int W = 4;
  localparam int S = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mask_we = 1'b0;
  logic [W-1:0] mask_wd = '0;
  logic inval = 1'b0;
  logic fill_req = 1'b0;
  logic [3:0] fill_set = '0;
  logic resp_valid, evict, no_victim;
  logic [W-1:0] victim;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  bit [W-1:0] vm [S];
  bit [W-1:0] mm;

  always #5 clk = ~clk;

  lockway_victim_sel #(.NUM_WAYS(W), .NUM_SETS(S)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mask_we_i(mask_we), .mask_wdata_i(mask_wd),
    .inval_all_i(inval), .fill_req_i(fill_req), .fill_set_i(fill_set),
    .resp_valid_o(resp_valid), .victim_o(victim), .evict_o(evict),
    .no_victim_o(no_victim)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit [W-1:0] lowest(input bit [W-1:0] v);
    for (int i = W - 1; i >= 0; i--) if (v[i]) lowest = 0;
    lowest = '0;
    for (int i = 0; i < W; i++) if (v[i]) begin lowest[i] = 1'b1; break; end
  endfunction

  task automatic set_mask(input bit [W-1:0] m);
    mask_we = 1'b1; mask_wd = m;
    @(negedge clk);
    mask_we = 1'b0;
    mm = m;
  endtask

  task automatic inval_all();
    inval = 1'b1;
    @(negedge clk);
    inval = 1'b0;
    for (int s = 0; s < S; s++) vm[s] = '0;
  endtask

  task automatic fill(input int s);
    fill_req = 1'b1; fill_set = 4'(s);
    @(negedge clk);
    fill_req = 1'b0;
  endtask

  // fill and compare against the valid/mask model, then update the model
  task automatic fill_chk(input int s, input string tag);
    bit [W-1:0] av, fr, e;
    fill(s);
    av = ~mm; fr = av & ~vm[s];
    if (av == '0) begin
      chk(resp_valid && no_victim && victim == '0 && !evict, tag, {no_victim, evict, victim}, 32'h20);
    end else if (fr != '0) begin
      e = lowest(fr);
      chk(resp_valid && !no_victim && !evict && victim == e, tag, {no_victim, evict, victim}, {2'b00, e});
      vm[s] |= e;
    end else begin
      chk(resp_valid && !no_victim && evict && $countones(victim) == 1 && (victim & ~av) == '0,
          tag, {no_victim, evict, victim}, {2'b01, av});
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int cnt [W];
    mm = '0;
    for (int s = 0; s < S; s++) vm[s] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!resp_valid && victim == '0 && !evict && !no_victim, "R1 outputs", {resp_valid, victim}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    fill(9);
    chk(victim == 4'b0001 && !evict && !no_victim, "R1 empty after reset", victim, 1);
    vm[9] = 4'b0001;
    // R2 idle cycle after a response
    @(negedge clk);
    chk(!resp_valid && victim == '0, "R2 idle", {resp_valid, victim}, 0);

    // R3/R4/R5/R6 sweep over every mask and set
    for (int m = 0; m < 16; m++) begin
      set_mask(4'(m));
      inval_all();
      for (int s = 0; s < S; s++)
        for (int i = 0; i <= W; i++) fill_chk(s, "R3 R4 R5 R6 sweep");
    end

    // R6 no update when all locked
    set_mask(4'b0000); inval_all();
    set_mask(4'b1111);
    fill(5); fill(5);
    chk(no_victim && victim == '0 && !evict, "R6 no victim", {no_victim, victim}, 32'h10);
    set_mask(4'b0000);
    fill(5);
    chk(victim == 4'b0001 && !evict, "R6 valid untouched", {evict, victim}, 1);

    // R7 preload into way 2 only
    inval_all();
    set_mask(4'b1011);
    for (int s = 0; s < S; s++) begin
      fill(s);
      chk(victim == 4'b0100 && !evict, "R7 preload", victim, 4);
      fill(s);
      chk(victim == 4'b0100 && evict, "R7 preload refill", {evict, victim}, 32'h14);
    end

    // R8 lock then unlock keeps lines valid
    set_mask(4'b0100);
    for (int i = 0; i < 3; i++) fill(2);
    set_mask(4'b0010);
    fill(2);
    chk(evict && (victim & 4'b0010) == '0 && victim != '0, "R8 locked lines still valid", {evict, victim}, 32'h10);
    set_mask(4'b0000);
    fill(2);
    chk(evict, "R8 after unlock set full", evict, 1);

    // R9 same-cycle write uses old mask, next cycle new mask
    inval_all();
    set_mask(4'b0000);
    mask_we = 1'b1; mask_wd = 4'b0001; fill_req = 1'b1; fill_set = 4'd7;
    @(negedge clk);
    mask_we = 1'b0;
    chk(victim == 4'b0001, "R9 old mask same cycle", victim, 1);
    fill_req = 1'b1; fill_set = 4'd8;
    @(negedge clk);
    fill_req = 1'b0;
    chk(victim == 4'b0010, "R9 new mask next cycle", victim, 2);

    // R10 invalidate-all keeps mask
    set_mask(4'b0011);
    fill(4); fill(4);
    inval_all();
    fill(4);
    chk(victim == 4'b0100 && !evict, "R10 cleared, mask kept", {evict, victim}, 4);
    fill(8);
    chk(victim == 4'b0100 && !evict, "R10 other set cleared", {evict, victim}, 4);

    // R5 spread with way 2 locked
    set_mask(4'b0100);
    inval_all();
    for (int i = 0; i < 3; i++) fill(3);
    for (int i = 0; i < W; i++) cnt[i] = 0;
    for (int i = 0; i < 300; i++) begin
      fill(3);
      for (int j = 0; j < W; j++) if (victim[j]) cnt[j]++;
    end
    chk(cnt[2] == 0, "R5 locked way unused", cnt[2], 0);
    chk(cnt[0] > 50 && cnt[0] < 150, "R5 spread way0", cnt[0], 100);
    chk(cnt[1] > 50 && cnt[1] < 150, "R5 spread way1", cnt[1], 100);
    chk(cnt[3] > 50 && cnt[3] < 150, "R5 spread way3", cnt[3], 100);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule